// File: doc/BRIEF.md
# Five-Stage In-Order Pipeline Core

This block is a 32-bit in-order processor core with five stages: fetch, decode, execute, memory access and write-back. Registers sit between each pair of stages. A new instruction enters the pipeline on every clock, so up to five instructions are in flight at once. Instruction storage and data storage are two separate internal arrays. A load or store in the memory stage therefore never competes with fetch for a port, and fetch never stalls.

The core does not detect hazards and does not forward operands. Only one path helps: a register that is being written back is also visible to a decode read in the same cycle. A program must place a consumer at least three slots after its producer. Branches are resolved in the memory stage. The three instructions that follow a branch always execute.

Software loads both memories through a word-wide preload port, normally while reset is held. A debug port reads any architectural register combinationally.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_ni` is low, and for the first cycles after it rises, every pipeline register holds a no-op. The PC is 0 and every general register reads 0. No register write occurs until the first fetched instruction reaches write-back, and no data memory write occurs until it reaches the memory stage.
- R2: The register instructions write the result to register D (bits 15:11), using A (bits 25:21) and B (bits 20:16) as sources:
  - opcode 0x01 adds, A+B
  - opcode 0x02 subtracts, A-B
  - opcode 0x03 is bitwise AND
  - opcode 0x04 is bitwise OR
- R3: Opcode 0x05 writes A plus the sign-extended 16-bit immediate (bits 15:0) into register B.
- R4: Opcode 0x06 loads the data word at byte address A+imm into register B. The word index is address bits [DMEM_AW+1:2].
- R5: Opcode 0x07 stores register B to the data word at byte address A+imm. A later load from that address returns the stored value.
- R6: Register 0 always reads 0, and writes that target it are dropped.
- R7: A source register that is being written back in the cycle its reader is in decode yields the new value. A reader three slots after its writer sees the result.
- R8: Opcode 0x08 compares A with B. If they are equal, the PC becomes (branch PC + 4) + (imm << 2) in the cycle after the branch reaches the memory stage. The three instructions fetched after the branch still execute. If A and B differ, execution falls through.
- R9: Apart from a taken branch, the PC advances by 4 on every cycle. Independent instructions issued back to back all complete, including across loads and stores.
- R10: The preload port writes `ld_data_i` into the instruction memory when `ld_dmem_i`=0 and into the data memory when `ld_dmem_i`=1, at word index `ld_addr_i`.
- R11: Opcode 0x00 and every opcode above 0x08 are no-ops: they write no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_we_i | input | 1 | Preload write strobe |
| ld_dmem_i | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| ld_addr_i | input | LD_AW | Preload word index |
| ld_data_i | input | 32 | Preload word |
| dbg_addr_i | input | 5 | Register index to observe |
| dbg_data_o | output | 32 | Contents of the observed register |

## Verification
The checker watches several rules on every cycle:
- the PC advances by four, or jumps to the target latched in the memory stage when a branch is taken
- register and data memory writes stay quiet right after reset
- a load in the memory stage becomes a load-select write in write-back
- decoded unknown opcodes carry no control
- register 0 reads as zero

The arithmetic results, the use of the immediate, the store-then-load round trip, the same-cycle write-through, and the execution of the three slots after a taken branch can only be shown by the bench's programs. The bench reads the final register contents through the debug port.

// File: rtl/pipe5_pkg.sv
`timescale 1ns/1ps
package pipe5_pkg;
  localparam int XW = 32;

  typedef enum logic [5:0] {
    OP_NOP  = 6'h00,
    OP_ADD  = 6'h01,
    OP_SUB  = 6'h02,
    OP_AND  = 6'h03,
    OP_OR   = 6'h04,
    OP_ADDI = 6'h05,
    OP_LW   = 6'h06,
    OP_SW   = 6'h07,
    OP_BEQ  = 6'h08
  } opcode_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    mem_rd;
    logic    mem_wr;
    logic    use_imm;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;

  typedef struct packed {
    logic [XW-1:0] instr;
    logic [XW-1:0] pc4;
  } ifid_t;

  typedef struct packed {
    logic [5:0]    opcode;
    ctrl_t         ctrl;
    logic [XW-1:0] a_val;
    logic [XW-1:0] b_val;
    logic [XW-1:0] imm;
    logic [XW-1:0] pc4;
    logic [4:0]    rd;
  } idex_t;

  typedef struct packed {
    logic          rf_we;
    logic          mem_rd;
    logic          mem_wr;
    logic          branch;
    logic          br_cond;
    logic [XW-1:0] alu_res;
    logic [XW-1:0] b_val;
    logic [XW-1:0] br_target;
    logic [4:0]    rd;
  } exmem_t;

  typedef struct packed {
    logic          rf_we;
    logic          mem_rd;
    logic [XW-1:0] alu_res;
    logic [XW-1:0] ld_data;
    logic [4:0]    rd;
  } memwb_t;
endpackage

// File: rtl/pipe5_decode.sv
`timescale 1ns/1ps
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [XW-1:0] instr_i,
  output ctrl_t         ctrl_o,
  output logic [4:0]    a_addr_o,
  output logic [4:0]    b_addr_o,
  output logic [4:0]    rd_o,
  output logic [XW-1:0] imm_o
);
  assign a_addr_o = instr_i[25:21];
  assign b_addr_o = instr_i[20:16];
  assign imm_o    = {{(XW-16){instr_i[15]}}, instr_i[15:0]};

  always_comb begin
    ctrl_o = '0;
    rd_o   = '0;
    case (opcode_e'(instr_i[31:26]))
      OP_ADD: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_ADD; rd_o = instr_i[15:11]; end
      OP_SUB: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_SUB; rd_o = instr_i[15:11]; end
      OP_AND: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_AND; rd_o = instr_i[15:11]; end
      OP_OR:  begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_OR;  rd_o = instr_i[15:11]; end
      OP_ADDI: begin
        ctrl_o.rf_we = 1'b1; ctrl_o.use_imm = 1'b1; rd_o = instr_i[20:16];
      end
      OP_LW: begin
        ctrl_o.rf_we = 1'b1; ctrl_o.use_imm = 1'b1; ctrl_o.mem_rd = 1'b1; rd_o = instr_i[20:16];
      end
      OP_SW:  begin ctrl_o.use_imm = 1'b1; ctrl_o.mem_wr = 1'b1; end
      OP_BEQ: begin ctrl_o.branch = 1'b1; ctrl_o.alu_op = ALU_SUB; end
      default: ;
    endcase
  end
endmodule

// File: rtl/pipe5_alu.sv
`timescale 1ns/1ps
module pipe5_alu
  import pipe5_pkg::*;
(
  input  logic [XW-1:0] a_i,
  input  logic [XW-1:0] b_i,
  input  alu_op_e       op_i,
  output logic [XW-1:0] y_o,
  output logic          eq_o
);
  always_comb begin
    case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      default: y_o = a_i + b_i;
    endcase
  end

  assign eq_o = (a_i == b_i);
endmodule

// File: rtl/pipe5_regfile.sv
`timescale 1ns/1ps
module pipe5_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i [NRD],
  output logic [DW-1:0] rdata_o [NRD],
  input  logic [AW-1:0] dbg_addr_i,
  output logic [DW-1:0] dbg_data_o
);
  logic [DW-1:0] regs_q [NREG];
  logic          wr_ok;

  assign wr_ok = we_i && (waddr_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_ok) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  // write-through: decode sees the value retiring this cycle
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = (wr_ok && waddr_i == raddr_i[p]) ? wdata_i : regs_q[raddr_i[p]];
  end

  assign dbg_data_o = regs_q[dbg_addr_i];
endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int LD_AW   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_we_i,
  input  logic             ld_dmem_i,
  input  logic [LD_AW-1:0] ld_addr_i,
  input  logic [XW-1:0]    ld_data_i,
  input  logic [4:0]       dbg_addr_i,
  output logic [XW-1:0]    dbg_data_o
);
  localparam int IDEPTH = 1 << IMEM_AW;
  localparam int DDEPTH = 1 << DMEM_AW;

  logic [XW-1:0] imem [IDEPTH];
  logic [XW-1:0] dmem [DDEPTH];

  logic [XW-1:0] pc_q, pc_d, pc4;
  ifid_t  ifid_q,  ifid_d;
  idex_t  idex_q,  idex_d;
  exmem_t exmem_q, exmem_d;
  memwb_t memwb_q, memwb_d;

  // ---------------- fetch
  logic exm_take;
  assign pc4      = pc_q + XW'(4);
  assign exm_take = exmem_q.branch & exmem_q.br_cond;
  assign pc_d     = exm_take ? exmem_q.br_target : pc4;

  always_ff @(posedge clk_i) begin
    if (ld_we_i && !ld_dmem_i) imem[ld_addr_i[IMEM_AW-1:0]] <= ld_data_i;
  end

  assign ifid_d.instr = imem[pc_q[IMEM_AW+1:2]];
  assign ifid_d.pc4   = pc4;

  // ---------------- decode
  ctrl_t         dec_ctrl;
  logic [4:0]    dec_rd;
  logic [XW-1:0] dec_imm;
  logic [4:0]    rf_raddr [2];
  logic [XW-1:0] rf_rdata [2];
  logic [XW-1:0] wb_data;

  pipe5_decode u_dec (
    .instr_i  (ifid_q.instr),
    .ctrl_o   (dec_ctrl),
    .a_addr_o (rf_raddr[0]),
    .b_addr_o (rf_raddr[1]),
    .rd_o     (dec_rd),
    .imm_o    (dec_imm)
  );

  pipe5_regfile #(.NREG(32), .DW(XW), .NRD(2)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (memwb_q.rf_we),
    .waddr_i    (memwb_q.rd),
    .wdata_i    (wb_data),
    .raddr_i    (rf_raddr),
    .rdata_o    (rf_rdata),
    .dbg_addr_i (dbg_addr_i),
    .dbg_data_o (dbg_data_o)
  );

  always_comb begin
    idex_d.opcode = ifid_q.instr[31:26];
    idex_d.ctrl   = dec_ctrl;
    idex_d.a_val  = rf_rdata[0];
    idex_d.b_val  = rf_rdata[1];
    idex_d.imm    = dec_imm;
    idex_d.pc4    = ifid_q.pc4;
    idex_d.rd     = dec_rd;
  end

  // ---------------- execute
  logic [XW-1:0] alu_b, alu_y;
  logic          alu_eq;

  assign alu_b = idex_q.ctrl.use_imm ? idex_q.imm : idex_q.b_val;

  pipe5_alu u_alu (
    .a_i  (idex_q.a_val),
    .b_i  (alu_b),
    .op_i (idex_q.ctrl.alu_op),
    .y_o  (alu_y),
    .eq_o (alu_eq)
  );

  always_comb begin
    exmem_d.rf_we     = idex_q.ctrl.rf_we;
    exmem_d.mem_rd    = idex_q.ctrl.mem_rd;
    exmem_d.mem_wr    = idex_q.ctrl.mem_wr;
    exmem_d.branch    = idex_q.ctrl.branch;
    exmem_d.br_cond   = alu_eq;
    exmem_d.alu_res   = alu_y;
    exmem_d.b_val     = idex_q.b_val;
    exmem_d.br_target = idex_q.pc4 + {idex_q.imm[XW-3:0], 2'b00};
    exmem_d.rd        = idex_q.rd;
  end

  // ---------------- memory
  logic [DMEM_AW-1:0] dm_idx;
  assign dm_idx = exmem_q.alu_res[DMEM_AW+1:2];

  always_ff @(posedge clk_i) begin
    if (ld_we_i && ld_dmem_i)  dmem[ld_addr_i[DMEM_AW-1:0]] <= ld_data_i;
    else if (exmem_q.mem_wr)   dmem[dm_idx] <= exmem_q.b_val;
  end

  always_comb begin
    memwb_d.rf_we   = exmem_q.rf_we;
    memwb_d.mem_rd  = exmem_q.mem_rd;
    memwb_d.alu_res = exmem_q.alu_res;
    memwb_d.ld_data = exmem_q.mem_rd ? dmem[dm_idx] : '0;
    memwb_d.rd      = exmem_q.rd;
  end

  // ---------------- write-back
  assign wb_data = memwb_q.mem_rd ? memwb_q.ld_data : memwb_q.alu_res;

  // ---------------- stage registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      ifid_q  <= '0;
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      pc_q    <= pc_d;
      ifid_q  <= ifid_d;
      idex_q  <= idex_d;
      exmem_q <= exmem_d;
      memwb_q <= memwb_d;
    end
  end
endmodule

// File: rtl/pipe5_core_chk.sv
`timescale 1ns/1ps
module pipe5_core_chk
  import pipe5_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [XW-1:0] pc_i,
  input logic [XW-1:0] target_i,
  input logic          take_i,
  input logic          rf_we_i,
  input logic          dmem_we_i,
  input logic          exm_load_i,
  input logic          wbm_load_i,
  input logic [5:0]    idex_op_i,
  input ctrl_t         idex_ctrl_i,
  input logic [4:0]    dbg_addr_i,
  input logic [XW-1:0] dbg_data_i
);
  logic [2:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_rst <= '0;
    else if (since_rst != 3'd7)  since_rst <= since_rst + 3'd1;
  end

  // R1
  quiet_rf_after_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < 3'd4) |-> !rf_we_i);

  // R1
  quiet_dmem_after_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < 3'd3) |-> !dmem_we_i);

  // R9
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> (pc_i == $past(pc_i) + 32'd4));

  // R8
  pc_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (pc_i == $past(target_i)));

  // R4
  load_reaches_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exm_load_i |=> wbm_load_i);

  // R11
  unknown_op_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idex_op_i == 6'h00 || idex_op_i > 6'h08) |-> (idex_ctrl_i == '0));

  // R6
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_addr_i == 5'd0) |-> (dbg_data_i == '0));
endmodule

bind pipe5_core pipe5_core_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pc_i        (pc_q),
  .target_i    (exmem_q.br_target),
  .take_i      (exm_take),
  .rf_we_i     (memwb_q.rf_we),
  .dmem_we_i   (exmem_q.mem_wr),
  .exm_load_i  (exmem_q.mem_rd),
  .wbm_load_i  (memwb_q.mem_rd),
  .idex_op_i   (idex_q.opcode),
  .idex_ctrl_i (idex_q.ctrl),
  .dbg_addr_i  (dbg_addr_i),
  .dbg_data_i  (dbg_data_o)
);

// File: tb/pipe5_core_test.sv
`timescale 1ns/1ps
module pipe5_core_test;
  localparam logic [5:0] K_NOP = 6'h00, K_ADD = 6'h01, K_SUB = 6'h02, K_AND = 6'h03,
                         K_OR = 6'h04, K_ADDI = 6'h05, K_LW = 6'h06, K_SW = 6'h07,
                         K_BEQ = 6'h08;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_we = 1'b0;
  logic        ld_dmem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [4:0]  r;
    logic [31:0] v;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  pipe5_core uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ld_we_i    (ld_we),
    .ld_dmem_i  (ld_dmem),
    .ld_addr_i  (ld_addr),
    .ld_data_i  (ld_data),
    .dbg_addr_i (dbg_addr),
    .dbg_data_o (dbg_data)
  );

  function automatic logic [31:0] enc_r(logic [5:0] op, int a, int b, int d);
    return {op, 5'(a), 5'(b), 5'(d), 11'd0};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int a, int b, int imm);
    return {op, 5'(a), 5'(b), 16'(imm)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_reg(input int r, input logic [31:0] v, input string tag);
    exp_t e;
    e.r = 5'(r); e.v = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor side: pops expectations and reads the register through the debug port
  task automatic drain();
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      @(negedge clk);
      dbg_addr = e.r;
      #1;
      chk(e.tag, dbg_data, e.v);
    end
  endtask

  task automatic put_word(input logic dm, input int a, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_dmem = dm; ld_addr = 6'(a); ld_data = d;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    dbg_addr = 5'd1;
    #1 chk("R1 reset r1", dbg_data, 32'h0);
    dbg_addr = 5'd9;
    #1 chk("R1 reset r9", dbg_data, 32'h0);
    for (int i = 0; i < 64; i++) put_word(1'b0, i, 32'h0);
  endtask

  task automatic run_prog(input int cycles);
    @(negedge clk);
    ld_we = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (cycles) @(posedge clk);
    drain();
  endtask

  initial begin
    #100_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // ---------- program 1: ALU, immediates, r0, unknown opcode, write-through
    enter_reset();
    put_word(1'b0, 0,  enc_i(K_ADDI, 0, 1, 5));
    put_word(1'b0, 1,  enc_i(K_ADDI, 0, 2, -3));
    put_word(1'b0, 2,  enc_i(K_ADDI, 0, 3, 32'h7FFF));
    put_word(1'b0, 3,  enc_i(K_ADDI, 0, 0, 9));
    put_word(1'b0, 4,  enc_r(6'h3F, 1, 10, 10));
    put_word(1'b0, 5,  enc_r(K_ADD, 1, 2, 4));
    put_word(1'b0, 6,  enc_r(K_SUB, 1, 2, 5));
    put_word(1'b0, 7,  enc_r(K_AND, 1, 3, 6));
    put_word(1'b0, 8,  enc_r(K_OR,  2, 1, 7));
    put_word(1'b0, 9,  enc_i(K_ADDI, 0, 8, 100));
    put_word(1'b0, 12, enc_r(K_ADD, 8, 1, 9));
    put_word(1'b0, 13, enc_r(K_NOP, 0, 0, 0));
    expect_reg(0,  32'h0,        "R6 r0 write dropped");
    expect_reg(1,  32'd5,        "R3 R9 r1");
    expect_reg(2,  32'hFFFFFFFD, "R3 sign-extended r2");
    expect_reg(3,  32'h00007FFF, "R3 R9 r3");
    expect_reg(4,  32'd2,        "R2 add");
    expect_reg(5,  32'd8,        "R2 sub");
    expect_reg(6,  32'd5,        "R2 and");
    expect_reg(7,  32'hFFFFFFFD, "R2 or");
    expect_reg(8,  32'd100,      "R9 r8");
    expect_reg(9,  32'd105,      "R7 write-through");
    expect_reg(10, 32'h0,        "R11 unknown opcode");
    run_prog(40);

    // ---------- program 2: memory and branches
    enter_reset();
    put_word(1'b1, 4, 32'hCAFEF00D);
    put_word(1'b1, 5, 32'h0);
    put_word(1'b0, 0,  enc_i(K_ADDI, 0, 1, 16));
    put_word(1'b0, 3,  enc_i(K_LW,   1, 2, 0));
    put_word(1'b0, 4,  enc_i(K_ADDI, 0, 3, 32'h1234));
    put_word(1'b0, 7,  enc_i(K_SW,   1, 3, 4));
    put_word(1'b0, 8,  enc_i(K_LW,   1, 4, 4));
    put_word(1'b0, 9,  enc_i(K_BEQ,  0, 0, 6));
    put_word(1'b0, 10, enc_i(K_ADDI, 0, 5, 7));
    put_word(1'b0, 11, enc_i(K_ADDI, 0, 6, 8));
    put_word(1'b0, 12, enc_i(K_ADDI, 0, 7, 9));
    put_word(1'b0, 13, enc_i(K_ADDI, 0, 11, 1));
    put_word(1'b0, 14, enc_i(K_ADDI, 0, 11, 1));
    put_word(1'b0, 15, enc_i(K_ADDI, 0, 11, 1));
    put_word(1'b0, 16, enc_i(K_BEQ,  1, 0, 4));
    put_word(1'b0, 17, enc_i(K_ADDI, 0, 12, 3));
    put_word(1'b0, 20, enc_i(K_ADDI, 0, 13, 44));
    expect_reg(1,  32'd16,       "R3 base r1");
    expect_reg(2,  32'hCAFEF00D, "R4 R10 load of preloaded word");
    expect_reg(3,  32'h1234,     "R3 r3");
    expect_reg(4,  32'h1234,     "R5 store then load");
    expect_reg(5,  32'd7,        "R8 slot 1 runs");
    expect_reg(6,  32'd8,        "R8 slot 2 runs");
    expect_reg(7,  32'd9,        "R8 slot 3 runs");
    expect_reg(11, 32'h0,        "R8 skipped by taken branch");
    expect_reg(12, 32'd3,        "R8 slot after untaken branch");
    expect_reg(13, 32'd44,       "R8 untaken falls through");
    run_prog(40);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule